// File: doc/BRIEF.md
# Program memory table access unit

This unit gives byte-granular access to a program memory that is organised in 16-bit words, so that constant lookup data can be packed two bytes into each word. A byte-address pointer register chooses the location. A one-byte data latch holds the byte most recently fetched from memory, or the byte that the next write will store. Each command moves exactly one byte between the latch and the memory. A write changes only the addressed byte lane of the word.

A command is either a table read or a table write, and it carries a pointer mode: keep the pointer, increment it after the access, or increment it before the access. Pointer bit 0 selects the lane: 0 is the low byte and 1 is the high byte. The upper pointer bits form the word address. The memory answers a request with one cycle of latency. The unit covers that latency with a busy indication and ends every command with a one-cycle done pulse.

The controller is a five-state machine.
- IDLE waits for work.
- PREINC advances the pointer when the command uses pre-increment.
- ISSUE drives the memory request.
- WAIT captures the returned byte into the latch on a read, and applies any post-increment.
- DONE pulses the done output.

The transitions are as follows.
- IDLE or DONE goes to PREINC on a pre-increment command, to ISSUE on any other command, and to IDLE when there is no command.
- PREINC goes to ISSUE.
- ISSUE goes to WAIT.
- WAIT goes to DONE.

Top module: `tblx_unit`

## Requirements
- R1: After reset the pointer is 0, the latch is 0, and busy, done and mem_req are all 0.
- R2: When the unit is in IDLE or DONE and cmd_valid is low, ptr_load writes ptr_wdata into the pointer and latch_load writes latch_wdata into the latch. Both loads take effect at the next clock edge.
- R3: A read (cmd_write=0) requests word address ptr[20:1]. It then loads the latch with bits [7:0] of the returned word when ptr[0]=0, or with bits [15:8] when ptr[0]=1.
- R4: A write (cmd_write=1) requests with mem_we=1. It drives mem_be=2'b01 when ptr[0]=0 and mem_be=2'b10 when ptr[0]=1, and places the latch byte on both halves of mem_wdata. The other byte of the word stays unchanged, and the latch does not change.
- R5: cmd_mode encodes the pointer mode: 0 keeps the pointer, 1 increments it by one after the access, 2 increments it by one before the access, and 3 behaves like 0. With mode 1, the access uses the old pointer value.
- R6: With mode 2, the pointer is incremented first and the access uses the incremented value.
- R7: busy is high in the cycle after a command is accepted. done is a single-cycle pulse that is never high together with busy. It appears three cycles after the accepting edge for modes 0, 1 and 3, and four cycles after it for mode 2.
- R8: While busy is high, cmd_valid, ptr_load and latch_load are ignored.
- R9: Incrementing the pointer wraps it from 21'h1FFFFF to 0.
- R10: Every command produces exactly one cycle of mem_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cmd_valid | input | 1 | start a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_mode | input | 2 | pointer mode |
| ptr_load | input | 1 | load the pointer |
| ptr_wdata | input | 21 | pointer load value |
| latch_load | input | 1 | load the latch |
| latch_wdata | input | 8 | latch load value |
| ptr_q | output | 21 | pointer register |
| latch_q | output | 8 | data latch |
| busy | output | 1 | command in progress |
| done | output | 1 | command finished pulse |
| mem_req | output | 1 | memory access request |
| mem_we | output | 1 | memory write enable |
| mem_addr | output | 20 | memory word address |
| mem_be | output | 2 | byte-lane enables |
| mem_wdata | output | 16 | write data, latch byte on both lanes |
| mem_rdata | input | 16 | read data, valid one cycle after mem_req |

## Verification
Reads are tried at even and odd pointers with each pointer mode. Even against odd pointers shows whether the lane is selected from bit 0. Post-increment against pre-increment shows whether the access uses the old or the new pointer value.

Writes go to both lanes of the same word, and each is followed by a read-back of the neighbouring byte. This shows whether a write leaves the other lane intact.

Commands and loads are injected while a command is in progress, which shows whether the busy guard holds. Increments at the pointer's top value check the wrap.

// File: rtl/tblx_pkg.sv
package tblx_pkg;
    typedef enum logic [1:0] {
        STEP_KEEP = 2'd0,
        STEP_POST = 2'd1,
        STEP_PRE  = 2'd2,
        STEP_ALT  = 2'd3
    } step_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PREINC,
        S_ISSUE,
        S_WAIT,
        S_DONE
    } tstate_e;
endpackage

// File: rtl/tblx_ptr.sv
module tblx_ptr #(
    parameter int PTR_W = 21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [PTR_W-1:0] ld_val,
    input  logic             step,
    output logic [PTR_W-1:0] ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n)    ptr <= '0;
        else if (step) ptr <= ptr + 1'b1;
        else if (ld)   ptr <= ld_val;
    end

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ld) && !$past(step)) |-> $stable(ptr));
endmodule

// File: rtl/tblx_lane.sv
module tblx_lane #(
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [BYTE_W-1:0] wbyte,
    input  logic [WORD_W-1:0] rword,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] wword,
    output logic [BYTE_W-1:0] rbyte
);
    logic [BYTE_W-1:0] pick [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g] = (sel == SEL_W'(g));
        assign wword[g*BYTE_W +: BYTE_W] = wbyte;
        assign pick[g] = rword[g*BYTE_W +: BYTE_W];
    end

    assign rbyte = pick[sel];

    always_comb begin
        assert_be_onehot_R4: assert ($countones(be) == 1);
    end
endmodule

// File: rtl/tblx_ctrl.sv
module tblx_ctrl
    import tblx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic       cmd_write,
    input  logic [1:0] cmd_mode,
    input  logic       ptr_load,
    input  logic       latch_load,
    output logic       mem_req,
    output logic       mem_we,
    output logic       ptr_step,
    output logic       ptr_ld_en,
    output logic       latch_cap,
    output logic       latch_ld_en,
    output logic       busy,
    output logic       done
);
    tstate_e state, nxt;
    step_e   mode_q;
    logic    wr_q;
    logic    open_w;
    logic    accept;

    assign open_w = (state == S_IDLE) || (state == S_DONE);
    assign accept = open_w && cmd_valid;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            mode_q <= STEP_KEEP;
            wr_q   <= 1'b0;
        end else begin
            state <= nxt;
            if (accept) begin
                mode_q <= step_e'(cmd_mode);
                wr_q   <= cmd_write;
            end
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE, S_DONE: begin
                if (accept) nxt = (step_e'(cmd_mode) == STEP_PRE) ? S_PREINC : S_ISSUE;
                else        nxt = S_IDLE;
            end
            S_PREINC: nxt = S_ISSUE;
            S_ISSUE:  nxt = S_WAIT;
            S_WAIT:   nxt = S_DONE;
            default:  nxt = S_IDLE;
        endcase
    end

    always_comb begin
        mem_req     = 1'b0;
        mem_we      = 1'b0;
        ptr_step    = 1'b0;
        latch_cap   = 1'b0;
        busy        = 1'b0;
        done        = 1'b0;
        ptr_ld_en   = open_w && !cmd_valid && ptr_load;
        latch_ld_en = open_w && !cmd_valid && latch_load;
        unique case (state)
            S_IDLE: ;
            S_PREINC: begin
                busy     = 1'b1;
                ptr_step = 1'b1;
            end
            S_ISSUE: begin
                busy    = 1'b1;
                mem_req = 1'b1;
                mem_we  = wr_q;
            end
            S_WAIT: begin
                busy      = 1'b1;
                latch_cap = !wr_q;
                ptr_step  = (mode_q == STEP_POST);
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assert_one_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);
    assert_busy_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_done_after_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(mem_req, 2));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/tblx_unit.sv
module tblx_unit #(
    parameter int PTR_W  = 21,
    parameter int WORD_W = 16,
    parameter int BYTE_W = 8,
    localparam int LANES = WORD_W / BYTE_W,
    localparam int SEL_W = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int ADDR_W = PTR_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_write,
    input  logic [1:0]        cmd_mode,
    input  logic              ptr_load,
    input  logic [PTR_W-1:0]  ptr_wdata,
    input  logic              latch_load,
    input  logic [BYTE_W-1:0] latch_wdata,
    output logic [PTR_W-1:0]  ptr_q,
    output logic [BYTE_W-1:0] latch_q,
    output logic              busy,
    output logic              done,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    logic              ptr_step, ptr_ld_en, latch_cap, latch_ld_en;
    logic [BYTE_W-1:0] rbyte;

    tblx_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_write(cmd_write), .cmd_mode(cmd_mode),
        .ptr_load(ptr_load), .latch_load(latch_load),
        .mem_req(mem_req), .mem_we(mem_we),
        .ptr_step(ptr_step), .ptr_ld_en(ptr_ld_en),
        .latch_cap(latch_cap), .latch_ld_en(latch_ld_en),
        .busy(busy), .done(done)
    );

    tblx_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n),
        .ld(ptr_ld_en), .ld_val(ptr_wdata),
        .step(ptr_step), .ptr(ptr_q)
    );

    tblx_lane #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_lane (
        .sel(ptr_q[SEL_W-1:0]), .wbyte(latch_q), .rword(mem_rdata),
        .be(mem_be), .wword(mem_wdata), .rbyte(rbyte)
    );

    assign mem_addr = ptr_q[PTR_W-1:SEL_W];

    always_ff @(posedge clk) begin
        if (!rst_n)           latch_q <= '0;
        else if (latch_cap)   latch_q <= rbyte;
        else if (latch_ld_en) latch_q <= latch_wdata;
    end

    assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_q) |-> $past(latch_cap || latch_ld_en));
endmodule

// File: tb/sim_tblx_unit.sv
module sim_tblx_unit;
    logic        clk = 0, rst_n = 0;
    logic        cmd_valid = 0, cmd_write = 0, ptr_load = 0, latch_load = 0;
    logic [1:0]  cmd_mode = 0;
    logic [20:0] ptr_wdata = 0, ptr_q;
    logic [7:0]  latch_wdata = 0, latch_q;
    logic        busy, done, mem_req, mem_we;
    logic [19:0] mem_addr;
    logic [1:0]  mem_be;
    logic [15:0] mem_wdata, mem_rdata;

    int total = 0, bad = 0, cyc = 0, nreq = 0;
    logic [15:0] mem  [256];
    logic [15:0] refm [256];
    logic [19:0] last_addr;
    logic [1:0]  last_be;
    logic [15:0] last_wd;
    logic        last_we;
    logic [7:0]  sb_q [$];
    logic [20:0] exp_ptr = 0;
    logic [7:0]  exp_latch = 0;

    always #4 clk = ~clk;

    tblx_unit u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        mem_rdata <= 16'hxxxx;
        if (mem_req) begin
            nreq++;
            last_addr <= mem_addr; last_be <= mem_be; last_we <= mem_we; last_wd <= mem_wdata;
            if (mem_we) begin
                if (mem_be[0]) mem[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
                if (mem_be[1]) mem[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
            end
            mem_rdata <= mem[mem_addr[7:0]];
        end
        if (cyc > 20000) begin
            bad++; total++;
            $display("FAIL watchdog act=%0d exp=0", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // monitor: latch compared with scoreboard on every done pulse
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sb_q.size() == 0) chk("R7 unexpected done", 1, 0);
            else chk("R3 R4 latch on done", latch_q, sb_q.pop_front());
        end
    end

    task automatic setp(input logic [20:0] v);
        @(negedge clk); ptr_load = 1; ptr_wdata = v;
        @(negedge clk); ptr_load = 0;
        exp_ptr = v;
        chk("R2 pointer load", ptr_q, v);
    endtask

    task automatic setl(input logic [7:0] v);
        @(negedge clk); latch_load = 1; latch_wdata = v;
        @(negedge clk); latch_load = 0;
        exp_latch = v;
        chk("R2 latch load", latch_q, v);
    endtask

    task automatic run(input bit wr, input logic [1:0] mode, input bit poke);
        logic [20:0] eff, after;
        int k, r0;
        bit seen;
        eff   = (mode == 2) ? exp_ptr + 21'd1 : exp_ptr;
        after = (mode == 1 || mode == 2) ? exp_ptr + 21'd1 : exp_ptr;
        if (wr) begin
            if (eff[0]) refm[eff[8:1]][15:8] = exp_latch;
            else        refm[eff[8:1]][7:0]  = exp_latch;
        end else begin
            exp_latch = eff[0] ? refm[eff[8:1]][15:8] : refm[eff[8:1]][7:0];
        end
        sb_q.push_back(exp_latch);
        @(negedge clk);
        r0 = nreq;
        cmd_valid = 1; cmd_write = wr; cmd_mode = mode;
        @(negedge clk);
        cmd_valid = 0;
        chk("R7 busy after accept", busy, 1);
        if (poke) begin
            cmd_valid = 1; cmd_write = 1; cmd_mode = 1;
            ptr_load = 1; ptr_wdata = 21'h0AAAA; latch_load = 1; latch_wdata = 8'hEE;
        end
        k = 1; seen = 0;
        while (!seen && k < 10) begin
            @(negedge clk);
            k++;
            cmd_valid = 0; ptr_load = 0; latch_load = 0;
            if (done) seen = 1;
        end
        chk("R7 done latency", k, (mode == 2) ? 4 : 3);
        chk("R10 one request", nreq - r0, 1);
        chk("R5 R6 R9 pointer after", ptr_q, after);
        chk("R3 word address", last_addr, eff[20:1]);
        chk("R4 write enable", last_we, wr);
        if (wr) begin
            chk("R4 byte lane", last_be, eff[0] ? 2'b10 : 2'b01);
            chk("R4 write data", last_wd, {exp_latch, exp_latch});
        end
        exp_ptr = after;
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]  = {8'(i) ^ 8'h5A, 8'(i)};
            refm[i] = {8'(i) ^ 8'h5A, 8'(i)};
        end
        repeat (3) @(negedge clk);
        chk("R1 ptr reset", ptr_q, 0);
        chk("R1 latch reset", latch_q, 0);
        chk("R1 busy reset", busy, 0);
        chk("R1 done reset", done, 0);
        chk("R1 req reset", mem_req, 0);
        rst_n = 1;
        setp(21'h000000);
        run(0, 0, 0);            // R3 low lane, R5 keep
        run(0, 1, 0);            // R5 post-increment
        run(0, 0, 0);            // R3 high lane
        run(0, 2, 0);            // R6 pre-increment
        run(0, 3, 0);            // R5 mode 3 keeps
        setp(21'h000002);
        setl(8'hA5);
        run(1, 1, 0);            // R4 low-lane write
        setl(8'h3C);
        run(1, 0, 0);            // R4 high-lane write
        setp(21'h000002);
        run(0, 1, 0);            // readback low
        run(0, 0, 0);            // readback high
        setp(21'h000010);
        setl(8'h77);
        run(1, 2, 0);            // R4 R6 write odd via pre-inc
        setp(21'h000010);
        run(0, 0, 0);            // R4 other byte intact
        run(0, 2, 1);            // R8 pokes while busy
        setp(21'h1FFFFF);
        run(0, 1, 0);            // R9 wrap after
        setp(21'h1FFFFF);
        run(0, 2, 0);            // R9 wrap before
        repeat (3) @(negedge clk);
        chk("R7 scoreboard drained", sb_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule